// File: doc/BRIEF.md
# Operand Forwarding Select for a Six-Stage In-Order Pipeline

This block picks, for every source operand of every instruction still waiting for a value, where that value should come from. The pipeline has six stages: fetch, register read, address ALU (ALU1), data memory (MEM), arithmetic ALU (ALU2) and write-back. A load's data exists once it reaches the MEM/ALU2 latch. An arithmetic result exists once it reaches the ALU2/WB latch. Consumers sit in three latches: RF/ALU1, ALU1/MEM and MEM/ALU2. Each consumer needs each operand in a different stage, and that stage depends on its instruction class.

For each pending operand the block compares the source register with the destination of the two producer latches. It then outputs a 2-bit mux select that picks the register-file value, the MEM/ALU2 result or the ALU2/WB result. A value is forwarded in the first cycle it exists, even when the consumer only uses it stages later. Selects are registered, so a decision made from the latch contents in one cycle is presented in the next. The datapath, the register file and stall generation sit outside this block.

Top module: `opfwd_select`

## Requirements
- R1: Every select is 2 bits wide: 0 means the register file (no forwarding), 1 means the MEM/ALU2 result and 2 means the ALU2/WB result. Code 3 never appears. Selects are registered: each one reflects the inputs of the previous rising clock edge. A synchronous active-high reset clears all selects to 0.
- R2: The class codes are 0 register-register ALU op, 1 register-memory ALU op, 2 branch, 3 load and 4 store. Codes 5 to 7 read no operand and write no register.
- R3: A valid load in MEM/ALU2 is forwarded (select 1) to every pending operand with a matching register in RF/ALU1 and ALU1/MEM.
- R4: A valid load or ALU op (class 0, 1 or 3) in ALU2/WB is forwarded (select 2) to every pending operand with a matching register in RF/ALU1.
- R5: A valid ALU op (class 0 or 1) in ALU2/WB is forwarded (select 2) to pending matching operands in ALU1/MEM and MEM/ALU2. A load in ALU2/WB is never forwarded to those two latches, because that value was already forwarded one stage earlier.
- R6: An operand is pending only while its point of use is still ahead. The base (classes 1 to 4) is used in ALU1, so it is pending only in RF/ALU1. Store data (operand A of class 4) is used in MEM, so it is pending in RF/ALU1 and ALU1/MEM. Operand A of classes 0, 1 and 2, and operand B of classes 0 and 2, are used in ALU2, so they are pending through MEM/ALU2.
- R7: Nothing is forwarded from an invalid producer, from a producer that writes no register (branch, store, codes 5 to 7), from a producer whose destination is register 0, or to an invalid consumer.
- R8: When both producer latches match the same operand, the MEM/ALU2 source (select 1) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | RF/ALU1 latch holds an instruction |
| rx_cls | input | 3 | RF/ALU1 instruction class |
| rx_base | input | REG_W | RF/ALU1 base register |
| rx_opa | input | REG_W | RF/ALU1 operand A register |
| rx_opb | input | REG_W | RF/ALU1 operand B register |
| am_valid | input | 1 | ALU1/MEM latch holds an instruction |
| am_cls | input | 3 | ALU1/MEM instruction class |
| am_opa | input | REG_W | ALU1/MEM operand A register |
| am_opb | input | REG_W | ALU1/MEM operand B register |
| ma_valid | input | 1 | MEM/ALU2 latch holds an instruction |
| ma_cls | input | 3 | MEM/ALU2 instruction class |
| ma_dest | input | REG_W | MEM/ALU2 destination register |
| ma_opa | input | REG_W | MEM/ALU2 operand A register |
| ma_opb | input | REG_W | MEM/ALU2 operand B register |
| aw_valid | input | 1 | ALU2/WB latch holds an instruction |
| aw_cls | input | 3 | ALU2/WB instruction class |
| aw_dest | input | REG_W | ALU2/WB destination register |
| sel_rx_base | output | 2 | Select for the RF/ALU1 base |
| sel_rx_opa | output | 2 | Select for RF/ALU1 operand A |
| sel_rx_opb | output | 2 | Select for RF/ALU1 operand B |
| sel_am_opa | output | 2 | Select for ALU1/MEM operand A |
| sel_am_opb | output | 2 | Select for ALU1/MEM operand B |
| sel_ma_opa | output | 2 | Select for MEM/ALU2 operand A |
| sel_ma_opb | output | 2 | Select for MEM/ALU2 operand B |

## Verification
The block holds no state except its output registers, so a wrong decision shows up on the affected select exactly one clock after the latch contents that cause it. The sweep sets every producer class against every consumer class in all three consumer latches, with small register numbers so that matches, mismatches and register 0 all occur. A wrong pending rule or a wrong producer qualification therefore shows up as a select code that is wrong in that next cycle. The reference model derives each expected code from the cycle in which a result first exists and the stage that uses the operand, not from a per-slot table.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam logic [2:0] CL_ALU_RR = 3'd0;
  localparam logic [2:0] CL_ALU_RM = 3'd1;
  localparam logic [2:0] CL_BRANCH = 3'd2;
  localparam logic [2:0] CL_LOAD   = 3'd3;
  localparam logic [2:0] CL_STORE  = 3'd4;

  localparam logic [1:0] SEL_RF = 2'd0;
  localparam logic [1:0] SEL_MA = 2'd1;
  localparam logic [1:0] SEL_AW = 2'd2;

  // Consumer latch position: 1 = RF/ALU1, 2 = ALU1/MEM, 3 = MEM/ALU2
  localparam int POS_RX = 1;
  localparam int POS_AM = 2;
  localparam int POS_MA = 3;

  function automatic logic is_alu(input logic [2:0] c);
    return (c == CL_ALU_RR) || (c == CL_ALU_RM);
  endfunction
endpackage

// File: rtl/opfwd_use.sv
// Decides which operands of the instruction in one latch are still pending.
module opfwd_use #(
  parameter int POS = 1,
  localparam int NOPS = (POS == 1) ? 3 : 2
) (
  input  logic            valid,
  input  logic [2:0]      cls,
  output logic [NOPS-1:0] need
);
  import opfwd_pkg::*;

  localparam bit MEM_AHEAD  = (POS <= POS_AM);
  localparam bit ALU2_AHEAD = (POS <= POS_MA);

  logic a_alu, a_st, b_use;

  always_comb begin
    a_alu = (cls == CL_ALU_RR) || (cls == CL_ALU_RM) || (cls == CL_BRANCH);
    a_st  = (cls == CL_STORE);
    b_use = (cls == CL_ALU_RR) || (cls == CL_BRANCH);
  end

  assign need[0] = valid && ((a_alu && ALU2_AHEAD) || (a_st && MEM_AHEAD));
  assign need[1] = valid && b_use && ALU2_AHEAD;

  generate
    if (NOPS == 3) begin : g_base
      assign need[2] = valid && (cls inside {CL_ALU_RM, CL_BRANCH, CL_LOAD, CL_STORE});
    end
  endgenerate
endmodule

// File: rtl/opfwd_match.sv
// One operand slot: compare against both producers, apply priority.
module opfwd_match #(
  parameter int REG_W      = 5,
  parameter bit TAKE_MA    = 1'b1,
  parameter bit TAKE_AW_LD = 1'b1
) (
  input  logic             need,
  input  logic [REG_W-1:0] src,
  input  logic             ma_ld,
  input  logic [REG_W-1:0] ma_dest,
  input  logic             aw_ld,
  input  logic             aw_alu,
  input  logic [REG_W-1:0] aw_dest,
  output logic [1:0]       sel
);
  import opfwd_pkg::*;

  logic hit_ma, hit_aw;

  always_comb begin
    hit_ma = TAKE_MA && need && ma_ld && (src == ma_dest);
    hit_aw = need && (aw_alu || (TAKE_AW_LD && aw_ld)) && (src == aw_dest);
    sel    = hit_ma ? SEL_MA : (hit_aw ? SEL_AW : SEL_RF);
  end
endmodule

// File: rtl/opfwd_select.sv
module opfwd_select #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [2:0]       rx_cls,
  input  logic [REG_W-1:0] rx_base,
  input  logic [REG_W-1:0] rx_opa,
  input  logic [REG_W-1:0] rx_opb,
  input  logic             am_valid,
  input  logic [2:0]       am_cls,
  input  logic [REG_W-1:0] am_opa,
  input  logic [REG_W-1:0] am_opb,
  input  logic             ma_valid,
  input  logic [2:0]       ma_cls,
  input  logic [REG_W-1:0] ma_dest,
  input  logic [REG_W-1:0] ma_opa,
  input  logic [REG_W-1:0] ma_opb,
  input  logic             aw_valid,
  input  logic [2:0]       aw_cls,
  input  logic [REG_W-1:0] aw_dest,
  output logic [1:0]       sel_rx_base,
  output logic [1:0]       sel_rx_opa,
  output logic [1:0]       sel_rx_opb,
  output logic [1:0]       sel_am_opa,
  output logic [1:0]       sel_am_opb,
  output logic [1:0]       sel_ma_opa,
  output logic [1:0]       sel_ma_opb
);
  import opfwd_pkg::*;

  // Slot order: 0 rx_a, 1 rx_b, 2 rx_base, 3 am_a, 4 am_b, 5 ma_a, 6 ma_b
  localparam int NSLOT = 7;
  localparam logic [NSLOT-1:0] SLOT_MA_OK   = 7'b0011111;
  localparam logic [NSLOT-1:0] SLOT_AWLD_OK = 7'b0000111;

  logic [2:0] need_rx;
  logic [1:0] need_am, need_ma;
  logic [NSLOT-1:0] need;
  logic [REG_W-1:0] src [NSLOT];
  logic [1:0] sel_d [NSLOT];
  logic [1:0] sel_q [NSLOT];
  logic ma_ld, aw_ld, aw_alu;

  opfwd_use #(.POS(POS_RX)) u_use_rx (.valid(rx_valid), .cls(rx_cls), .need(need_rx));
  opfwd_use #(.POS(POS_AM)) u_use_am (.valid(am_valid), .cls(am_cls), .need(need_am));
  opfwd_use #(.POS(POS_MA)) u_use_ma (.valid(ma_valid), .cls(ma_cls), .need(need_ma));

  // Producer qualification: valid, writes a register, not register 0
  assign ma_ld  = ma_valid && (ma_cls == CL_LOAD) && (ma_dest != '0);
  assign aw_ld  = aw_valid && (aw_cls == CL_LOAD) && (aw_dest != '0);
  assign aw_alu = aw_valid && is_alu(aw_cls) && (aw_dest != '0);

  assign need = {need_ma, need_am, need_rx};

  always_comb begin
    src[0] = rx_opa;
    src[1] = rx_opb;
    src[2] = rx_base;
    src[3] = am_opa;
    src[4] = am_opb;
    src[5] = ma_opa;
    src[6] = ma_opb;
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      opfwd_match #(
        .REG_W(REG_W),
        .TAKE_MA(SLOT_MA_OK[g]),
        .TAKE_AW_LD(SLOT_AWLD_OK[g])
      ) u_match (
        .need(need[g]), .src(src[g]),
        .ma_ld(ma_ld), .ma_dest(ma_dest),
        .aw_ld(aw_ld), .aw_alu(aw_alu), .aw_dest(aw_dest),
        .sel(sel_d[g])
      );

      always_ff @(posedge clk) begin
        if (rst) sel_q[g] <= SEL_RF;
        else     sel_q[g] <= sel_d[g];
      end
    end
  endgenerate

  assign sel_rx_opa  = sel_q[0];
  assign sel_rx_opb  = sel_q[1];
  assign sel_rx_base = sel_q[2];
  assign sel_am_opa  = sel_q[3];
  assign sel_am_opb  = sel_q[4];
  assign sel_ma_opa  = sel_q[5];
  assign sel_ma_opb  = sel_q[6];
endmodule

// File: rtl/opfwd_select_chk.sv
module opfwd_select_chk #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic [2:0]       rx_cls,
  input logic [REG_W-1:0] rx_base,
  input logic             am_valid,
  input logic [2:0]       am_cls,
  input logic             ma_valid,
  input logic [2:0]       ma_cls,
  input logic [REG_W-1:0] ma_dest,
  input logic             aw_valid,
  input logic [2:0]       aw_cls,
  input logic [1:0]       sel_rx_base,
  input logic [1:0]       sel_rx_opa,
  input logic [1:0]       sel_rx_opb,
  input logic [1:0]       sel_am_opa,
  input logic [1:0]       sel_am_opb,
  input logic [1:0]       sel_ma_opa,
  input logic [1:0]       sel_ma_opb
);
  logic [13:0] all_sel;
  assign all_sel = {sel_rx_base, sel_rx_opa, sel_rx_opb, sel_am_opa, sel_am_opb, sel_ma_opa, sel_ma_opb};

  // R1: reset clears every select on the following cycle
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (all_sel == '0));

  // R1: code 3 is never produced
  a_r1_no_code3: assert property (@(posedge clk) disable iff (rst)
    (sel_rx_base != 2'd3) && (sel_rx_opa != 2'd3) && (sel_rx_opb != 2'd3) &&
    (sel_am_opa != 2'd3) && (sel_am_opb != 2'd3) && (sel_ma_opa != 2'd3) && (sel_ma_opb != 2'd3));

  // R7: no valid producer means no forwarding next cycle
  a_r7_idle_producers: assert property (@(posedge clk) disable iff (rst)
    (!ma_valid && !aw_valid) |=> (all_sel == '0));

  // R6: a register-register op never forwards its base
  a_r6_rr_no_base: assert property (@(posedge clk) disable iff (rst)
    (rx_cls == 3'd0) |=> (sel_rx_base == 2'd0));

  // R5: a lone load in ALU2/WB never reaches ALU1/MEM or MEM/ALU2
  a_r5_aw_load_late: assert property (@(posedge clk) disable iff (rst)
    (!ma_valid && aw_cls == 3'd3) |=>
      (sel_am_opa == 2'd0 && sel_am_opb == 2'd0 && sel_ma_opa == 2'd0 && sel_ma_opb == 2'd0));

  // R3 and R8: a matching load in MEM/ALU2 takes the base slot
  a_r3_load_to_base: assert property (@(posedge clk) disable iff (rst)
    (ma_valid && ma_cls == 3'd3 && ma_dest != '0 && rx_valid &&
     rx_cls inside {3'd1, 3'd2, 3'd3, 3'd4} && rx_base == ma_dest) |=> (sel_rx_base == 2'd1));

  // R7: invalid consumers in the later latches get no forwarding
  a_r7_invalid_consumer: assert property (@(posedge clk) disable iff (rst)
    (!am_valid) |=> (sel_am_opa == 2'd0 && sel_am_opb == 2'd0));
endmodule

bind opfwd_select opfwd_select_chk #(.NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/opfwd_select_tb_top.sv
module opfwd_select_tb_top;
  localparam int NR = 4;
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rst;
  logic rx_valid, am_valid, ma_valid, aw_valid;
  logic [2:0] rx_cls, am_cls, ma_cls, aw_cls;
  logic [RW-1:0] rx_base, rx_opa, rx_opb, am_opa, am_opb, ma_dest, ma_opa, ma_opb, aw_dest;
  logic [1:0] sel_rx_base, sel_rx_opa, sel_rx_opb, sel_am_opa, sel_am_opb, sel_ma_opa, sel_ma_opb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opfwd_select #(.NUM_REGS(NR)) dut_i (.*);

  // Reference: result exists at latch 3 (load) or 4 (ALU op); consumer
  // at latch L uses base at 1, store data at 2, ALU operands at 3.
  function automatic int avail_at(input int cls);
    if (cls == 3) return 3;
    if (cls == 0 || cls == 1) return 4;
    return 99;
  endfunction

  function automatic int use_at(input int kind, input int cls);
    if (kind == 2) return (cls >= 1 && cls <= 4) ? 1 : 0;
    if (kind == 0) begin
      if (cls == 4) return 2;
      return (cls <= 2) ? 3 : 0;
    end
    return (cls == 0 || cls == 2) ? 3 : 0;
  endfunction

  function automatic bit gives(input int p, input int l, input int pv, input int pcls,
                               input int pdest, input int creg);
    int av;
    av = avail_at(pcls);
    if (pv == 0 || pdest == 0 || pdest != creg || av > p || l >= p) return 0;
    return (av == p) || (l == 1);
  endfunction

  function automatic logic [1:0] ref_sel(input int l, input int kind, input int cv,
                                         input int ccls, input int creg);
    int u;
    u = use_at(kind, ccls);
    if (cv == 0 || u == 0 || u < l) return 2'd0;
    if (gives(3, l, ma_valid, ma_cls, ma_dest, creg)) return 2'd1;
    if (gives(4, l, aw_valid, aw_cls, aw_dest, creg)) return 2'd2;
    return 2'd0;
  endfunction

  task automatic cmp(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] e, input int l);
    if (e == 2'd1) return "R3";
    if (e == 2'd2) return (l == 1) ? "R4" : "R5";
    return "R7";
  endfunction

  // Inputs are already set; wait one edge, compare at the following negedge.
  task automatic step(input string force_tag);
    logic [1:0] e [7];
    e[0] = ref_sel(1, 2, rx_valid, rx_cls, rx_base);
    e[1] = ref_sel(1, 0, rx_valid, rx_cls, rx_opa);
    e[2] = ref_sel(1, 1, rx_valid, rx_cls, rx_opb);
    e[3] = ref_sel(2, 0, am_valid, am_cls, am_opa);
    e[4] = ref_sel(2, 1, am_valid, am_cls, am_opb);
    e[5] = ref_sel(3, 0, ma_valid, ma_cls, ma_opa);
    e[6] = ref_sel(3, 1, ma_valid, ma_cls, ma_opb);
    @(posedge clk);
    @(negedge clk);
    cmp((force_tag != "") ? force_tag : tag_of(e[0], 1), sel_rx_base, e[0]);
    cmp((force_tag != "") ? force_tag : tag_of(e[1], 1), sel_rx_opa, e[1]);
    cmp((force_tag != "") ? force_tag : tag_of(e[2], 1), sel_rx_opb, e[2]);
    cmp((force_tag != "") ? force_tag : tag_of(e[3], 2), sel_am_opa, e[3]);
    cmp((force_tag != "") ? force_tag : tag_of(e[4], 2), sel_am_opb, e[4]);
    cmp((force_tag != "") ? force_tag : tag_of(e[5], 3), sel_ma_opa, e[5]);
    cmp((force_tag != "") ? force_tag : tag_of(e[6], 3), sel_ma_opb, e[6]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    {rx_valid, am_valid, ma_valid, aw_valid} = 4'hF;
    rx_cls = 3'd0; am_cls = 3'd0; ma_cls = 3'd3; aw_cls = 3'd0;
    rx_base = 1; rx_opa = 1; rx_opb = 1; am_opa = 1; am_opb = 1;
    ma_dest = 1; ma_opa = 1; ma_opb = 1; aw_dest = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset holds every select at 0 despite matching inputs
    cmp("R1", sel_rx_base, 2'd0); cmp("R1", sel_rx_opa, 2'd0);
    cmp("R1", sel_am_opa, 2'd0);  cmp("R1", sel_ma_opb, 2'd0);
    rst = 1'b0;

    // R8: load in MEM/ALU2 and ALU op in ALU2/WB, same register
    rx_cls = 3'd0; ma_cls = 3'd3; aw_cls = 3'd0; ma_dest = 2; aw_dest = 2;
    rx_opa = 2; rx_opb = 2;
    step("R8");
    cmp("R8", sel_rx_opa, 2'd1);
    // R6: register-register op base never forwarded
    rx_base = 2; step("R6");
    cmp("R6", sel_rx_base, 2'd0);
    // R2: code 6 consumer reads nothing
    rx_cls = 3'd6; am_cls = 3'd6; ma_cls = 3'd6; aw_cls = 3'd1;
    am_opa = 2; am_opb = 2; step("R2");
    cmp("R2", sel_rx_opa, 2'd0);
    cmp("R2", sel_am_opa, 2'd0);
    // R1: registered, one cycle later
    @(negedge clk);
    rx_cls = 3'd0; aw_cls = 3'd0; aw_dest = 3; rx_opa = 3;
    @(posedge clk); #1;
    cmp("R1", sel_rx_opa, 2'd2);

    // Sweep all class pairings, destinations and operand register offsets
    for (int mc = 0; mc < 6; mc++)
      for (int ac = 0; ac < 6; ac++)
        for (int cc = 0; cc < 6; cc++)
          for (int md = 0; md < NR; md++)
            for (int ad = 0; ad < NR; ad++)
              for (int k = 0; k < NR; k++) begin
                int n;
                logic [4:0] v;
                @(negedge clk);
                n = ((mc * 6 + ac) * 6 + cc) * 64 + md * 16 + ad * 4 + k;
                v = n[4:0] ^ n[9:5] ^ 5'b11010;
                ma_valid = v[0] | v[4]; aw_valid = v[1] | v[4];
                rx_valid = v[2] | v[3]; am_valid = v[3] | v[1]; 
                ma_cls = 3'(mc); aw_cls = 3'(ac);
                rx_cls = 3'(cc); am_cls = 3'((cc + k) % 6);
                ma_dest = RW'(md); aw_dest = RW'(ad);
                rx_base = RW'(k); rx_opa = RW'(k + 1); rx_opb = RW'(k + 2);
                am_opa = RW'(k); am_opb = RW'(k + 3);
                ma_opa = RW'(k + 1); ma_opb = RW'(k);
                step("");
              end
    finish_run();
  end
endmodule